// File: doc/BRIEF.md
# Queue-Port Messaging Unit

This block is the device-side messaging unit that sits behind a host register window. The host talks to it with a simple 32-bit read/write bus. Two addresses act as queue ports. Reading the inbound port hands the host a free request frame, and writing the inbound port posts a request. Reading the outbound port collects a completion, and writing the outbound port gives a device-resident frame back to the pool. Each port fronts two FIFOs, one for each direction of access.

The device side refills the free-frame FIFO, pops posted requests, pushes completions and drains returned frames. A posted word is either a device-window offset, or has bit 31 set with a host bus address shifted right by 5 in the remaining bits. Host requests are 32-byte aligned, so nothing is lost in the shift. When a completion carries the output-context flag and its word is host-tagged, the low context word is queued in place of the tagged word. The unit also has:

- message registers in each direction, for non-queued commands. A command is done when the outbound message 0 matches the inbound message 0.
- a doorbell register.
- a status/mask pair for each direction, driving a device interrupt and a host interrupt.

Top module: `qpmu_top`

## Requirements
- R1: After reset, h_rdata and h_rvalid are 0, both interrupt lines are low, and the post and return FIFOs present no valid entry.
- R2: Host writes to offsets 0x10 and 0x14 land in the two inbound message registers, which the device sees on dev_imsg0/dev_imsg1 and the host reads back at the same offsets. Device writes to the outbound message registers are read by the host at 0x18 and 0x1C.
- R3: A host read of 0x40 returns the oldest frame pushed on the free-refill port and removes it. When no frame is held, the read returns 0xFFFFFFFF and removes nothing.
- R4: A host write to 0x40 posts the written word unchanged, including a bit-31 host tag, in arrival order. It is visible on dev_post_data with dev_post_valid the cycle after the write.
- R5: A completion is queued as dev_cpl_ctx_lo when dev_cpl_ctx_en is high and bit 31 of dev_cpl_word is set. In every other case it is queued as dev_cpl_word.
- R6: A host read of 0x44 returns and removes the oldest completion. When the completion FIFO is empty, the read returns 0xFFFFFFFF.
- R7: A host write to 0x44 queues the word for the device on dev_ret_data/dev_ret_valid, in order.
- R8: Bit 0 of the outbound status register (0x30) is set the cycle after the completion FIFO holds an entry. The bit stays set while the FIFO is non-empty. Once the FIFO is empty, writing 1 to bit 0 clears it.
- R9: host_irq is high exactly when some outbound status bit is set and its bit in the outbound mask (0x34, reset 0) is 0.
- R10: Every FIFO holds 32 entries. A push into a full FIFO is dropped and sets a sticky outbound status bit: bit 4 for free-refill, 5 for post, 6 for completion and 7 for return. Writing 1 to such a bit clears it.
- R11: A host write to 0x20 ORs its bits into the doorbell, which dev_db_clr clears bitwise. The inbound status at 0x24 has these bits:
  - bit 0 is set by a write to message 0.
  - bit 1 is set by a write to message 1.
  - bits 0 and 1 are cleared by dev_iclr.
  - bit 2 shows a non-zero doorbell.

  dev_irq is high when a status bit is set and its inbound mask bit (0x28) is 0.
- R12: A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host access strobe, one cycle per access |
| h_we | input | 1 | 1 = write, 0 = read |
| h_addr | input | 8 | Byte offset within the window |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Read data, registered |
| h_rvalid | output | 1 | High the cycle after a read |
| dev_post_valid | output | 1 | A posted request is waiting |
| dev_post_data | output | 32 | Oldest posted request word |
| dev_post_pop | input | 1 | Consume the posted request |
| dev_cpl_push | input | 1 | Push a completion |
| dev_cpl_word | input | 32 | Completion word (offset or tagged word) |
| dev_cpl_ctx_en | input | 1 | Output-context flag of the request |
| dev_cpl_ctx_lo | input | 32 | Low 32 bits of the request context |
| dev_free_push | input | 1 | Push a free frame offset |
| dev_free_data | input | 32 | Free frame offset |
| dev_ret_valid | output | 1 | A returned frame is waiting |
| dev_ret_data | output | 32 | Oldest returned frame |
| dev_ret_pop | input | 1 | Consume the returned frame |
| dev_imsg0 | output | 32 | Inbound message 0 |
| dev_imsg1 | output | 32 | Inbound message 1 |
| dev_omsg_we | input | 2 | Write strobes for outbound message 0/1 |
| dev_omsg_data | input | 32 | Outbound message data |
| dev_doorbell | output | 8 | Doorbell bits |
| dev_db_clr | input | 8 | Doorbell clear mask |
| dev_iclr | input | 2 | Clear inbound message status bits |
| dev_irq | output | 1 | Device-side interrupt |
| host_irq | output | 1 | Host-side outbound interrupt |

## Verification
The hardest state to reach is an overflow. To get there, one FIFO must be filled to its 32-entry limit while the other side deliberately stays idle. The bench does this with 33 back-to-back host writes to the outbound port, with no return pops. It then checks three things: the sticky status bit, that exactly 32 entries drain, and that the bit clears on write-1. Status bit 0 sets while the FIFO is non-empty and only clears on write-1 once the FIFO is empty. The bench covers this by draining every completion first and then clearing, and it checks the mask by pushing a completion while bit 0 is masked.

// File: rtl/qpmu_pkg.sv
package qpmu_pkg;
    localparam int WORD_W = 32;
    localparam int NUM_Q  = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [7:0]        reg_addr_t;

    // queue indices; overflow flag of queue k sits at outbound status bit 4+k
    localparam int Q_FREE = 0;
    localparam int Q_POST = 1;
    localparam int Q_CPL  = 2;
    localparam int Q_RET  = 3;

    localparam reg_addr_t A_IMSG0 = 8'h10;
    localparam reg_addr_t A_IMSG1 = 8'h14;
    localparam reg_addr_t A_OMSG0 = 8'h18;
    localparam reg_addr_t A_OMSG1 = 8'h1C;
    localparam reg_addr_t A_DBELL = 8'h20;
    localparam reg_addr_t A_ISTAT = 8'h24;
    localparam reg_addr_t A_IMASK = 8'h28;
    localparam reg_addr_t A_OSTAT = 8'h30;
    localparam reg_addr_t A_OMASK = 8'h34;
    localparam reg_addr_t A_INQ   = 8'h40;
    localparam reg_addr_t A_OUTQ  = 8'h44;

    localparam word_t EMPTY_WORD = '1;

    typedef struct packed {
        logic      rd;
        logic      wr;
        reg_addr_t addr;
        word_t     data;
    } host_op_t;

    function automatic word_t cpl_select(word_t w, logic ctx_en, word_t ctx_lo);
        return (ctx_en && w[WORD_W-1]) ? ctx_lo : w;
    endfunction
endpackage

// File: rtl/qpmu_fifo.sv
module qpmu_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             ovf
);
    localparam int PW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [PW:0]      cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == (PW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign ovf     = push && full;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end

    // R10
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= (PW+1)'(DEPTH));

    // R10
    drop_full_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/qpmu_irq.sv
module qpmu_irq
    import qpmu_pkg::*;
#(
    parameter int DBW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  host_op_t         op,
    input  logic             cpl_nonempty,
    input  logic [NUM_Q-1:0] q_ovf,
    input  logic [DBW-1:0]   db_clr,
    input  logic [1:0]       iclr,
    output logic [7:0]       ostat,
    output logic [7:0]       omask,
    output logic [2:0]       istat,
    output logic [7:0]       imask,
    output logic [DBW-1:0]   doorbell,
    output logic             host_irq,
    output logic             dev_irq
);
    logic [7:0]     w1c;
    logic [DBW-1:0] db_set;
    logic [1:0]     msg_evt;

    assign w1c     = (op.wr && op.addr == A_OSTAT) ? op.data[7:0] : 8'h00;
    assign db_set  = (op.wr && op.addr == A_DBELL) ? op.data[DBW-1:0] : '0;
    assign msg_evt = {op.wr && op.addr == A_IMSG1, op.wr && op.addr == A_IMSG0};

    always_ff @(posedge clk) begin
        if (rst) begin
            ostat      <= '0;
            omask      <= '0;
            imask      <= '0;
            istat[1:0] <= '0;
            doorbell   <= '0;
        end else begin
            ostat[0] <= cpl_nonempty | (ostat[0] & ~w1c[0]);
            for (int k = 0; k < NUM_Q; k++)
                ostat[4+k] <= q_ovf[k] | (ostat[4+k] & ~w1c[4+k]);
            ostat[3:1] <= '0;
            if (op.wr && op.addr == A_OMASK) omask <= op.data[7:0];
            if (op.wr && op.addr == A_IMASK) imask <= op.data[7:0];
            istat[1:0] <= msg_evt | (istat[1:0] & ~iclr);
            doorbell   <= (doorbell & ~db_clr) | db_set;
        end
    end

    assign istat[2] = |doorbell;
    assign host_irq = |(ostat & ~omask);
    assign dev_irq  = |(istat & ~imask[2:0]);

    // R8
    cpl_status_chk: assert property (@(posedge clk) disable iff (rst)
        cpl_nonempty |=> ostat[0]);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (|q_ovf) |=> (|ostat[7:4]));
endmodule

// File: rtl/qpmu_top.sv
module qpmu_top
    import qpmu_pkg::*;
#(
    parameter int QDEPTH = 32,
    parameter int DBW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             h_req,
    input  logic             h_we,
    input  logic [7:0]       h_addr,
    input  logic [31:0]      h_wdata,
    output logic [31:0]      h_rdata,
    output logic             h_rvalid,
    output logic             dev_post_valid,
    output logic [31:0]      dev_post_data,
    input  logic             dev_post_pop,
    input  logic             dev_cpl_push,
    input  logic [31:0]      dev_cpl_word,
    input  logic             dev_cpl_ctx_en,
    input  logic [31:0]      dev_cpl_ctx_lo,
    input  logic             dev_free_push,
    input  logic [31:0]      dev_free_data,
    output logic             dev_ret_valid,
    output logic [31:0]      dev_ret_data,
    input  logic             dev_ret_pop,
    output logic [31:0]      dev_imsg0,
    output logic [31:0]      dev_imsg1,
    input  logic [1:0]       dev_omsg_we,
    input  logic [31:0]      dev_omsg_data,
    output logic [DBW-1:0]   dev_doorbell,
    input  logic [DBW-1:0]   dev_db_clr,
    input  logic [1:0]       dev_iclr,
    output logic             dev_irq,
    output logic             host_irq
);
    host_op_t op;
    assign op = '{rd: h_req && !h_we, wr: h_req && h_we, addr: h_addr, data: h_wdata};

    logic             rd_inq, wr_inq, rd_outq, wr_outq;
    assign rd_inq  = op.rd && op.addr == A_INQ;
    assign wr_inq  = op.wr && op.addr == A_INQ;
    assign rd_outq = op.rd && op.addr == A_OUTQ;
    assign wr_outq = op.wr && op.addr == A_OUTQ;

    logic [NUM_Q-1:0] q_push, q_pop, q_empty, q_full, q_ovf;
    word_t            q_din  [NUM_Q];
    word_t            q_dout [NUM_Q];

    always_comb begin
        q_push[Q_FREE] = dev_free_push;
        q_din[Q_FREE]  = dev_free_data;
        q_pop[Q_FREE]  = rd_inq;
        q_push[Q_POST] = wr_inq;
        q_din[Q_POST]  = op.data;
        q_pop[Q_POST]  = dev_post_pop;
        q_push[Q_CPL]  = dev_cpl_push;
        q_din[Q_CPL]   = cpl_select(dev_cpl_word, dev_cpl_ctx_en, dev_cpl_ctx_lo);
        q_pop[Q_CPL]   = rd_outq;
        q_push[Q_RET]  = wr_outq;
        q_din[Q_RET]   = op.data;
        q_pop[Q_RET]   = dev_ret_pop;
    end

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        qpmu_fifo #(.WIDTH(WORD_W), .DEPTH(QDEPTH)) u_fifo (
            .clk  (clk),
            .rst  (rst),
            .push (q_push[g]),
            .pop  (q_pop[g]),
            .din  (q_din[g]),
            .dout (q_dout[g]),
            .empty(q_empty[g]),
            .full (q_full[g]),
            .ovf  (q_ovf[g])
        );
    end

    assign dev_post_valid = !q_empty[Q_POST];
    assign dev_post_data  = q_dout[Q_POST];
    assign dev_ret_valid  = !q_empty[Q_RET];
    assign dev_ret_data   = q_dout[Q_RET];

    logic [7:0] ostat, omask, imask;
    logic [2:0] istat;

    qpmu_irq #(.DBW(DBW)) u_irq (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .cpl_nonempty(!q_empty[Q_CPL]),
        .q_ovf       (q_ovf),
        .db_clr      (dev_db_clr),
        .iclr        (dev_iclr),
        .ostat       (ostat),
        .omask       (omask),
        .istat       (istat),
        .imask       (imask),
        .doorbell    (dev_doorbell),
        .host_irq    (host_irq),
        .dev_irq     (dev_irq)
    );

    word_t omsg0, omsg1;

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_imsg0 <= '0;
            dev_imsg1 <= '0;
            omsg0     <= '0;
            omsg1     <= '0;
            h_rdata   <= '0;
            h_rvalid  <= 1'b0;
        end else begin
            if (op.wr && op.addr == A_IMSG0) dev_imsg0 <= op.data;
            if (op.wr && op.addr == A_IMSG1) dev_imsg1 <= op.data;
            if (dev_omsg_we[0]) omsg0 <= dev_omsg_data;
            if (dev_omsg_we[1]) omsg1 <= dev_omsg_data;
            h_rvalid <= op.rd;
            if (op.rd) begin
                case (op.addr)
                    A_IMSG0: h_rdata <= dev_imsg0;
                    A_IMSG1: h_rdata <= dev_imsg1;
                    A_OMSG0: h_rdata <= omsg0;
                    A_OMSG1: h_rdata <= omsg1;
                    A_DBELL: h_rdata <= WORD_W'(dev_doorbell);
                    A_ISTAT: h_rdata <= WORD_W'(istat);
                    A_IMASK: h_rdata <= WORD_W'(imask);
                    A_OSTAT: h_rdata <= WORD_W'(ostat);
                    A_OMASK: h_rdata <= WORD_W'(omask);
                    A_INQ:   h_rdata <= q_empty[Q_FREE] ? EMPTY_WORD : q_dout[Q_FREE];
                    A_OUTQ:  h_rdata <= q_empty[Q_CPL]  ? EMPTY_WORD : q_dout[Q_CPL];
                    default: h_rdata <= '0;
                endcase
            end
        end
    end

    // R3
    empty_free_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_inq && q_empty[Q_FREE]) |=> (h_rdata == EMPTY_WORD));

    // R4
    post_land_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_inq && q_empty[Q_POST]) |=> (dev_post_valid && dev_post_data == $past(h_wdata)));

    // R6
    empty_cpl_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_outq && q_empty[Q_CPL]) |=> (h_rdata == EMPTY_WORD));
endmodule

// File: tb/tb_qpmu_top.sv
module tb_qpmu_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        h_req = 0, h_we = 0;
    logic [7:0]  h_addr = 0;
    logic [31:0] h_wdata = 0;
    logic [31:0] h_rdata;
    logic        h_rvalid;
    logic        dev_post_valid;
    logic [31:0] dev_post_data;
    logic        dev_post_pop = 0;
    logic        dev_cpl_push = 0;
    logic [31:0] dev_cpl_word = 0;
    logic        dev_cpl_ctx_en = 0;
    logic [31:0] dev_cpl_ctx_lo = 0;
    logic        dev_free_push = 0;
    logic [31:0] dev_free_data = 0;
    logic        dev_ret_valid;
    logic [31:0] dev_ret_data;
    logic        dev_ret_pop = 0;
    logic [31:0] dev_imsg0, dev_imsg1;
    logic [1:0]  dev_omsg_we = 0;
    logic [31:0] dev_omsg_data = 0;
    logic [7:0]  dev_doorbell;
    logic [7:0]  dev_db_clr = 0;
    logic [1:0]  dev_iclr = 0;
    logic        dev_irq, host_irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    qpmu_top dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        h_req = 1; h_we = 1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_req = 0; h_we = 0;
    endtask

    task automatic host_rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        h_req = 1; h_we = 0; h_addr = a;
        @(negedge clk);
        h_req = 0;
        d = h_rdata;
    endtask

    // {write, addr, data, check, expected}
    localparam int NV = 14;
    localparam logic [73:0] VEC [NV] = '{
        {1'b1, 8'h10, 32'h0000_1234, 1'b0, 32'h0},
        {1'b0, 8'h10, 32'h0,         1'b1, 32'h0000_1234},
        {1'b1, 8'h14, 32'hA5A5_0000, 1'b0, 32'h0},
        {1'b0, 8'h14, 32'h0,         1'b1, 32'hA5A5_0000},
        {1'b0, 8'h40, 32'h0,         1'b1, 32'hFFFF_FFFF},
        {1'b0, 8'h44, 32'h0,         1'b1, 32'hFFFF_FFFF},
        {1'b0, 8'h30, 32'h0,         1'b1, 32'h0},
        {1'b1, 8'h34, 32'h0000_00F0, 1'b0, 32'h0},
        {1'b0, 8'h34, 32'h0,         1'b1, 32'h0000_00F0},
        {1'b1, 8'h20, 32'h0000_0003, 1'b0, 32'h0},
        {1'b1, 8'h20, 32'h0000_0004, 1'b0, 32'h0},
        {1'b0, 8'h20, 32'h0,         1'b1, 32'h0000_0007},
        {1'b0, 8'h24, 32'h0,         1'b1, 32'h0000_0007},
        {1'b0, 8'h60, 32'h0,         1'b1, 32'h0}
    };

    function automatic string vec_req(logic [7:0] a);
        case (a)
            8'h10, 8'h14: return "R2";
            8'h40:        return "R3";
            8'h44:        return "R6";
            8'h30, 8'h34: return "R9";
            8'h20, 8'h24: return "R11";
            default:      return "R12";
        endcase
    endfunction

    task automatic cpl_push(logic [31:0] w, logic en, logic [31:0] c);
        @(negedge clk);
        dev_cpl_push = 1; dev_cpl_word = w; dev_cpl_ctx_en = en; dev_cpl_ctx_lo = c;
        @(negedge clk);
        dev_cpl_push = 0;
    endtask

    initial begin
        logic [31:0] rd;
        int cnt;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1", {h_rdata}, 32'h0);
        check("R1", {28'h0, h_rvalid, host_irq, dev_post_valid, dev_ret_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][73]) host_wr(VEC[i][72:65], VEC[i][64:33]);
            else begin
                host_rd(VEC[i][72:65], rd);
                if (VEC[i][32]) check(vec_req(VEC[i][72:65]), rd, VEC[i][31:0]);
            end
        end
        host_wr(8'h34, 32'h0);

        // R2 device-side message views and outbound messages
        check("R2", dev_imsg0, 32'h0000_1234);
        check("R2", dev_imsg1, 32'hA5A5_0000);
        @(negedge clk); dev_omsg_we = 2'b01; dev_omsg_data = 32'h0000_1234;
        @(negedge clk); dev_omsg_we = 2'b10; dev_omsg_data = 32'h0BAD_F00D;
        @(negedge clk); dev_omsg_we = 2'b00;
        host_rd(8'h18, rd); check("R2", rd, 32'h0000_1234);
        host_rd(8'h1C, rd); check("R2", rd, 32'h0BAD_F00D);

        // R11 doorbell and inbound interrupt
        check("R11", {31'h0, dev_irq}, 32'h1);
        check("R11", {24'h0, dev_doorbell}, 32'h7);
        host_wr(8'h28, 32'h7);
        check("R11", {31'h0, dev_irq}, 32'h0);
        @(negedge clk); dev_iclr = 2'b11; dev_db_clr = 8'hFF;
        @(negedge clk); dev_iclr = 0; dev_db_clr = 0;
        host_rd(8'h24, rd); check("R11", rd, 32'h0);
        host_rd(8'h20, rd); check("R11", rd, 32'h0);

        // R3 free frames
        @(negedge clk); dev_free_push = 1; dev_free_data = 32'h0000_0100;
        @(negedge clk); dev_free_data = 32'h0000_0200;
        @(negedge clk); dev_free_push = 0;
        host_rd(8'h40, rd); check("R3", rd, 32'h0000_0100);
        host_rd(8'h40, rd); check("R3", rd, 32'h0000_0200);
        host_rd(8'h40, rd); check("R3", rd, 32'hFFFF_FFFF);

        // R4 posts
        host_wr(8'h40, 32'h8000_0010);
        check("R4", {31'h0, dev_post_valid}, 32'h1);
        check("R4", dev_post_data, 32'h8000_0010);
        host_wr(8'h40, 32'h0000_0300);
        @(negedge clk); dev_post_pop = 1;
        @(negedge clk); dev_post_pop = 0;
        check("R4", dev_post_data, 32'h0000_0300);
        @(negedge clk); dev_post_pop = 1;
        @(negedge clk); dev_post_pop = 0;
        check("R4", {31'h0, dev_post_valid}, 32'h0);

        // R5/R6/R8 completions
        check("R8", {31'h0, host_irq}, 32'h0);
        cpl_push(32'h8000_0010, 1'b1, 32'hCAFE_0001);
        // fifo written at first edge, status at next edge: now one edge passed
        @(negedge clk);
        check("R8", {31'h0, host_irq}, 32'h1);
        cpl_push(32'h0000_0300, 1'b1, 32'hCAFE_0002);
        cpl_push(32'h8000_0020, 1'b0, 32'hCAFE_0003);
        host_rd(8'h44, rd); check("R5", rd, 32'hCAFE_0001);
        host_rd(8'h44, rd); check("R5", rd, 32'h0000_0300);
        host_rd(8'h44, rd); check("R5", rd, 32'h8000_0020);
        host_rd(8'h44, rd); check("R6", rd, 32'hFFFF_FFFF);
        host_rd(8'h30, rd); check("R8", rd, 32'h1);
        host_wr(8'h30, 32'h1);
        host_rd(8'h30, rd); check("R8", rd, 32'h0);
        check("R8", {31'h0, host_irq}, 32'h0);

        // R9 mask
        host_wr(8'h34, 32'h1);
        cpl_push(32'h0000_0400, 1'b0, 32'h0);
        @(negedge clk);
        check("R9", {31'h0, host_irq}, 32'h0);
        host_rd(8'h30, rd); check("R9", rd, 32'h1);
        host_wr(8'h34, 32'h0);
        check("R9", {31'h0, host_irq}, 32'h1);
        host_rd(8'h44, rd); check("R6", rd, 32'h0000_0400);
        host_wr(8'h30, 32'h1);
        check("R9", {31'h0, host_irq}, 32'h0);

        // R7 returns
        host_wr(8'h44, 32'h0000_0500);
        check("R7", {31'h0, dev_ret_valid}, 32'h1);
        check("R7", dev_ret_data, 32'h0000_0500);
        @(negedge clk); dev_ret_pop = 1;
        @(negedge clk); dev_ret_pop = 0;
        check("R7", {31'h0, dev_ret_valid}, 32'h0);

        // R10 overflow of the return FIFO
        for (int i = 0; i < 33; i++) host_wr(8'h44, 32'h1000 + i);
        host_rd(8'h30, rd); check("R10", rd, 32'h80);
        check("R10", {31'h0, host_irq}, 32'h1);
        check("R10", dev_ret_data, 32'h0000_1000);
        cnt = 0;
        @(negedge clk); dev_ret_pop = 1;
        for (int i = 0; i < 40; i++) begin
            if (dev_ret_valid) cnt++;
            @(negedge clk);
        end
        dev_ret_pop = 0;
        check("R10", cnt, 32);
        host_wr(8'h30, 32'h80);
        host_rd(8'h30, rd); check("R10", rd, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule